// File: doc/BRIEF.md
# Keyed Watchdog Register Interface

This block is the bus-facing register set of a watchdog timer. It keeps an 8-bit count register, an 8-bit control register and a reset control/status register. The register that carries the overflow flag also holds the reset-enable and reset-select bits. The counting clock, the prescaler and the reset pulse generator sit outside the block. They take the register values from dedicated outputs and report an overflow on `ovf_pulse_i`.

Every write is guarded. It must be a 16-bit access with both byte lanes enabled at an even byte offset. Its upper byte is a key that chooses what happens, and its lower byte carries the data. A write that fails any of these rules is dropped without a trace. Reads are single-byte accesses, and the addressed byte appears combinationally on `bus_rdata_o`.

Top module: `wdt_keyed_regs`

## Requirements
- R1: After reset, offsets 0, 1 and 2 read 0x00, offset 3 reads 0x1F, and `cnt_load_o` is 0.
- R2: An accepted write at offset 0 with key 0x5A stores the low byte in the count register, which then reads at offset 1 and drives `cnt_val_o`.
- R3: An accepted write at offset 0 with key 0xA5 stores the low byte in the control register, which then reads at offset 0.
- R4: `cnt_load_o` is high for exactly the one cycle that follows each accepted count write, and stays low after every other access.
- R5: An accepted write at offset 2 with key 0xA5 and low byte 0x00 clears the overflow flag (offset 3 bit 7) and leaves bits 6 and 5 unchanged.
- R6: An accepted write at offset 2 with key 0x5A copies low-byte bit 6 into reset-enable (offset 3 bit 6) and bit 5 into reset-select (offset 3 bit 5), and leaves the overflow flag unchanged.
- R7: A 16-bit write whose key is neither 0x5A nor 0xA5 changes no register.
- R8: A write is ignored if its size code is not 1, its byte enables are not 2'b11, or its offset is odd. Size codes are 0 for byte, 1 for 16-bit and 2 for 32-bit; byte-enable bit 1 is the key lane.
- R9: A high cycle on `ovf_pulse_i` sets the overflow flag, and this set wins over a clearing write in the same cycle.
- R10: Offset 0 reads the control register, offset 1 reads the count register and offset 3 reads the reset control/status register. Offset 2 reads 0x00, and offset 3 bits 4:0 read 1.
- R11: A write at offset 2 with key 0xA5 and a nonzero low byte changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Byte offset |
| bus_size_i | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| bus_be_i | input | 2 | Byte enables; bit 1 is the key lane |
| bus_wdata_i | input | 16 | Write data: key in [15:8], data in [7:0] |
| bus_rdata_o | output | 8 | Addressed byte, combinational |
| ovf_pulse_i | input | 1 | Overflow event from the counter |
| cnt_val_o | output | 8 | Count register value |
| ctl_o | output | 8 | Control register value |
| cnt_load_o | output | 1 | One-cycle reload strobe after a count write |
| ovf_flag_o | output | 1 | Overflow flag |
| rst_en_o | output | 1 | Reset-enable bit |
| rst_sel_o | output | 1 | Reset-select bit |

## Verification
The bench builds the block with its default parameters: 8-bit registers, keys 0x5A and 0xA5, and flag bits at positions 7, 6 and 5. With these values each key can be tried at each even offset, and the bench can feed it the neighbouring wrong values: foreign keys, byte and 32-bit sizes, a missing lane enable and odd offsets. The vector walk keeps a running register state, so a wrongly accepted write shows up as a changed readback. The directed tests place an overflow pulse in the same cycle as a clearing write, and they check the reload strobe in the cycle after a count write and in the cycle after that.

// File: rtl/wdt_regs_pkg.sv
package wdt_regs_pkg;
  localparam int unsigned AW = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [AW-1:0] OFS_CTL  = 2'd0;
  localparam logic [AW-1:0] OFS_CNT  = 2'd1;
  localparam logic [AW-1:0] OFS_RCSR = 2'd3;
endpackage

// File: rtl/wdt_wr_decode.sv
module wdt_wr_decode
  import wdt_regs_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter logic [DW-1:0] KEY_LD = 8'h5A,
  parameter logic [DW-1:0] KEY_AL = 8'hA5
) (
  input  logic            sel_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      size_i,
  input  logic [1:0]      be_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic            wr_cnt_o,
  output logic            wr_ctl_o,
  output logic            wr_clr_o,
  output logic            wr_rctl_o
);
  logic [DW-1:0] key, lo;
  logic          ok, hi_word;

  assign key     = wdata_i[2*DW-1:DW];
  assign lo      = wdata_i[DW-1:0];
  assign hi_word = addr_i[1];

  // legal write shape: 16-bit, both lanes, even offset
  assign ok = sel_i && we_i && (acc_size_e'(size_i) == SZ_HALF)
              && (be_i == 2'b11) && !addr_i[0];

  assign wr_cnt_o  = ok && !hi_word && (key == KEY_LD);
  assign wr_ctl_o  = ok && !hi_word && (key == KEY_AL);
  assign wr_clr_o  = ok &&  hi_word && (key == KEY_AL) && (lo == '0);
  assign wr_rctl_o = ok &&  hi_word && (key == KEY_LD);
endmodule

// File: rtl/wdt_byte_reg.sv
module wdt_byte_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/wdt_rst_csr.sv
module wdt_rst_csr #(
  parameter int unsigned DW      = 8,
  parameter int unsigned OVF_BIT = 7,
  parameter int unsigned EN_BIT  = 6,
  parameter int unsigned SEL_BIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic          en_d_i,
  input  logic          sel_d_i,
  input  logic          ovf_set_i,
  output logic          ovf_o,
  output logic          en_o,
  output logic          sel_o,
  output logic [DW-1:0] csr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      en_o  <= 1'b0;
      sel_o <= 1'b0;
    end else begin
      if (ovf_set_i)  ovf_o <= 1'b1;   // set beats clear
      else if (clr_i) ovf_o <= 1'b0;
      if (ld_i) begin
        en_o  <= en_d_i;
        sel_o <= sel_d_i;
      end
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == OVF_BIT)      begin : g_ovf assign csr_o[i] = ovf_o; end
    else if (i == EN_BIT)  begin : g_en  assign csr_o[i] = en_o;  end
    else if (i == SEL_BIT) begin : g_sel assign csr_o[i] = sel_o; end
    else                   begin : g_one assign csr_o[i] = 1'b1;  end
  end

  AST_OVF_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_o); // R9
  AST_OVF_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ovf_set_i) |=> !ovf_o); // R5
  AST_CLR_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ld_i) |=> ($stable(en_o) && $stable(sel_o))); // R5
  AST_LD_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i && !ovf_set_i) |=> $stable(ovf_o)); // R6
endmodule

// File: rtl/wdt_rd_mux.sv
module wdt_rd_mux
  import wdt_regs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] ctl_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] rcsr_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      OFS_CTL:  rdata_o = ctl_i;
      OFS_CNT:  rdata_o = cnt_i;
      OFS_RCSR: rdata_o = rcsr_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_regs_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter logic [DW-1:0] KEY_LD = 8'h5A,
  parameter logic [DW-1:0] KEY_AL = 8'hA5,
  parameter int unsigned OVF_BIT  = 7,
  parameter int unsigned EN_BIT   = 6,
  parameter int unsigned SEL_BIT  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_sel_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [1:0]      bus_size_i,
  input  logic [1:0]      bus_be_i,
  input  logic [2*DW-1:0] bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic            ovf_pulse_i,
  output logic [DW-1:0]   cnt_val_o,
  output logic [DW-1:0]   ctl_o,
  output logic            cnt_load_o,
  output logic            ovf_flag_o,
  output logic            rst_en_o,
  output logic            rst_sel_o
);
  localparam int unsigned BW = 2 * DW;

  logic          wr_cnt, wr_ctl, wr_clr, wr_rctl;
  logic [DW-1:0] lo, rcsr;

  assign lo = bus_wdata_i[DW-1:0];

  wdt_wr_decode #(.DW(DW), .KEY_LD(KEY_LD), .KEY_AL(KEY_AL)) u_dec (
    .sel_i    (bus_sel_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .size_i   (bus_size_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i[BW-1:0]),
    .wr_cnt_o (wr_cnt),
    .wr_ctl_o (wr_ctl),
    .wr_clr_o (wr_clr),
    .wr_rctl_o(wr_rctl)
  );

  wdt_byte_reg #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .we_i(wr_cnt), .d_i(lo), .q_o(cnt_val_o)
  );

  wdt_byte_reg #(.DW(DW)) u_ctl (
    .clk_i, .rst_ni, .we_i(wr_ctl), .d_i(lo), .q_o(ctl_o)
  );

  wdt_rst_csr #(.DW(DW), .OVF_BIT(OVF_BIT), .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT)) u_rcsr (
    .clk_i, .rst_ni,
    .clr_i    (wr_clr),
    .ld_i     (wr_rctl),
    .en_d_i   (lo[EN_BIT]),
    .sel_d_i  (lo[SEL_BIT]),
    .ovf_set_i(ovf_pulse_i),
    .ovf_o    (ovf_flag_o),
    .en_o     (rst_en_o),
    .sel_o    (rst_sel_o),
    .csr_o    (rcsr)
  );

  wdt_rd_mux #(.DW(DW)) u_rd (
    .addr_i(bus_addr_i), .ctl_i(ctl_o), .cnt_i(cnt_val_o),
    .rcsr_i(rcsr), .rdata_o(bus_rdata_o)
  );

  // reload strobe, aligned with the new count value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_load_o <= 1'b0;
    else         cnt_load_o <= wr_cnt;
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_cnt, wr_ctl, wr_clr, wr_rctl})); // R8
  AST_CNT_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt_load_o && cnt_val_o == $past(lo))); // R2
  AST_LOAD_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> (!cnt_load_o && $stable(cnt_val_o))); // R4
  AST_CTL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctl |=> $stable(ctl_o)); // R7
  AST_NO_WRITE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |-> !(wr_cnt || wr_ctl || wr_clr || wr_rctl)); // R8
endmodule

// File: tb/wdt_keyed_regs_bench.sv
module wdt_keyed_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0, bus_size_i = '0, bus_be_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o, cnt_val_o, ctl_o;
  logic        ovf_pulse_i = 1'b0;
  logic        cnt_load_o, ovf_flag_o, rst_en_o, rst_sel_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  wdt_keyed_regs u_wdt_keyed_regs (.*);

  // {size, be, addr, wdata, rd_addr, exp, req}
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {2'd1, 2'b11, 2'd0, 16'h5A3C, 2'd1, 8'h3C, 4'd2},  // R2
    {2'd1, 2'b11, 2'd0, 16'hA5C7, 2'd0, 8'hC7, 4'd3},  // R3
    {2'd1, 2'b11, 2'd0, 16'h7711, 2'd1, 8'h3C, 4'd7},  // R7
    {2'd1, 2'b11, 2'd0, 16'hA611, 2'd0, 8'hC7, 4'd7},
    {2'd0, 2'b11, 2'd0, 16'h5AFF, 2'd1, 8'h3C, 4'd8},  // R8 byte
    {2'd2, 2'b11, 2'd0, 16'hA5FF, 2'd0, 8'hC7, 4'd8},  // 32-bit
    {2'd1, 2'b01, 2'd0, 16'h5AFF, 2'd1, 8'h3C, 4'd8},  // lane missing
    {2'd1, 2'b11, 2'd1, 16'h5A11, 2'd1, 8'h3C, 4'd8},  // odd offset
    {2'd1, 2'b11, 2'd2, 16'h5A60, 2'd3, 8'h7F, 4'd6},  // R6
    {2'd1, 2'b11, 2'd2, 16'h5A40, 2'd3, 8'h5F, 4'd6},
    {2'd0, 2'b11, 2'd2, 16'h5A20, 2'd3, 8'h5F, 4'd8},
    {2'd2, 2'b11, 2'd2, 16'h5A00, 2'd3, 8'h5F, 4'd8},
    {2'd1, 2'b11, 2'd2, 16'h5A20, 2'd3, 8'h3F, 4'd6},
    {2'd1, 2'b11, 2'd0, 16'h5A99, 2'd2, 8'h00, 4'd10}, // R10
    {2'd1, 2'b11, 2'd0, 16'h0099, 2'd1, 8'h99, 4'd7},
    {2'd1, 2'b11, 2'd2, 16'hA500, 2'd3, 8'h3F, 4'd5}   // R5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sz, input logic [1:0] be,
                        input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1;
    bus_size_i = sz; bus_be_i = be; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr_i = a;
    #1;
    chk(req, bus_rdata_o, exp);
  endtask

  task automatic ovf_hit();
    @(negedge clk_i); ovf_pulse_i = 1'b1;
    @(negedge clk_i); ovf_pulse_i = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd1, 8'h00);
    rd_chk("R1", 2'd2, 8'h00);
    rd_chk("R1", 2'd3, 8'h1F);
    chk("R1", {7'd0, cnt_load_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      bus_wr(v[35:34], v[33:32], v[31:30], v[29:14]);
      rd_chk($sformatf("R%0d vec%0d", v[3:0], i), v[13:12], v[11:4]);
    end
    // state: ctl C7, cnt 99, ovf0 en0 sel1
    chk("R2", cnt_val_o, 8'h99);
    chk("R3", ctl_o, 8'hC7);

    // R9 overflow pulse sets flag
    ovf_hit();
    rd_chk("R9", 2'd3, 8'hBF);
    chk("R9", {7'd0, ovf_flag_o}, 8'h01);
    // R11 clear key with nonzero data ignored
    bus_wr(2'd1, 2'b11, 2'd2, 16'hA501);
    rd_chk("R11", 2'd3, 8'hBF);
    // R6 control load keeps flag
    bus_wr(2'd1, 2'b11, 2'd2, 16'h5A40);
    rd_chk("R6", 2'd3, 8'hDF);
    chk("R6", {6'd0, rst_en_o, rst_sel_o}, 8'h02);
    // R5 clear keeps control bits
    bus_wr(2'd1, 2'b11, 2'd2, 16'hA500);
    rd_chk("R5", 2'd3, 8'h5F);
    // R9 simultaneous set and clear: set wins
    ovf_hit();
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_size_i = 2'd1; bus_be_i = 2'b11;
    bus_addr_i = 2'd2; bus_wdata_i = 16'hA500; ovf_pulse_i = 1'b1;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0; ovf_pulse_i = 1'b0;
    rd_chk("R9", 2'd3, 8'hDF);
    bus_wr(2'd1, 2'b11, 2'd2, 16'hA500);
    rd_chk("R5", 2'd3, 8'h5F);

    // R4 reload strobe
    bus_wr(2'd1, 2'b11, 2'd0, 16'h5A55);
    chk("R4", {7'd0, cnt_load_o}, 8'h01);
    chk("R2", cnt_val_o, 8'h55);
    @(negedge clk_i);
    chk("R4", {7'd0, cnt_load_o}, 8'h00);
    bus_wr(2'd1, 2'b11, 2'd0, 16'hA555);
    chk("R4", {7'd0, cnt_load_o}, 8'h00);
    bus_wr(2'd0, 2'b11, 2'd0, 16'h5A66);
    chk("R4", {7'd0, cnt_load_o}, 8'h00);
    rd_chk("R8", 2'd1, 8'h55);
    rd_chk("R10", 2'd0, 8'h55);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule